// File: doc/BRIEF.md
# SPI Slave Transaction Engine

This block is the byte engine of an SPI slave. An external master clocks bytes in on MOSI and out on MISO while chip select is low. Each received byte is written to a receive buffer port, and each transmitted byte is read from a transmit buffer port. Separate per-transaction limits apply to each direction. The serial pins are brought into the system clock domain through synchronizers, and every edge is detected there. The system clock must run at least four times faster than SCK.

When chip select falls, the engine samples a grant input that comes from a semaphore arbiter. A granted transaction moves data between the pins and the buffer ports. Receive bytes beyond the receive limit are dropped. Once the transmit limit is used up, a fill character replaces transmit bytes, and in both cases a sticky error flag is raised. An ungranted transaction only answers with a default character.

When a granted transaction ends, the engine publishes how many bytes moved in each direction and emits a one-cycle end pulse. A separate pulse marks the moment the receive buffer reaches its limit.

Top module: `spi_slave_xfer`

## Requirements
- R1: In all four clock modes (cpol_i = idle level of SCK; cpha_i = 0 samples MOSI on the leading edge and changes MISO on the trailing edge, cpha_i = 1 the reverse), bytes are exchanged correctly with the master.
- R2: lsb_first_i = 0 shifts each byte most significant bit first on both lines; lsb_first_i = 1 shifts least significant bit first.
- R3: While chip select is high, miso_oe_o is 0 and miso_o is 0.
- R4: If grant_i is low in the cycle chip select falls, the transaction is ungranted. MISO carries def_char_i for every byte, nothing is written, no end pulse is raised, and the amount outputs keep their values. A grant arriving later in the same transaction changes none of this.
- R5: In a granted transaction, received byte k is written at rx_addr_o = k only while k < max_rx_i. Later bytes are discarded and set overflow_o, which stays set until it is cleared.
- R6: In a granted transaction, transmit byte k comes from tx_addr_o = k while k < max_tx_i. Later bytes send orc_char_i. overread_o is set when the first bit of such a fill byte is clocked, and stays set until it is cleared. Clocking exactly max_tx_i bytes does not set it.
- R7: When a granted transaction ends, rx_amount_o becomes the number of bytes written, and tx_amount_o becomes the number of whole buffer bytes sent, with fill bytes excluded.
- R8: end_rx_o pulses for one cycle, together with the write that brings the receive count to max_rx_i. It never pulses when max_rx_i is 0.
- R9: end_o pulses exactly once, for one cycle, after chip select rises at the end of a granted transaction.
- R10: A one-cycle pulse on clr_overflow_i or clr_overread_i clears the matching flag, unless that flag is being set in the same cycle.
- R11: If chip select rises in the middle of a byte, the partial byte is neither written nor counted.
- R12: After reset, miso_oe_o, both flags, all pulses and both amount outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | Bit order, 1 selects least significant bit first |
| max_rx_i | input | CNT_W | Receive limit per transaction |
| max_tx_i | input | CNT_W | Transmit limit per transaction |
| def_char_i | input | 8 | Byte sent in ungranted transactions |
| orc_char_i | input | 8 | Fill byte sent past the transmit limit |
| grant_i | input | 1 | Buffer ownership from the semaphore arbiter |
| tx_addr_o | output | CNT_W | Transmit buffer byte address |
| tx_rd_o | output | 1 | Transmit read strobe; tx_data_i is taken in this cycle |
| tx_data_i | input | 8 | Transmit buffer data for tx_addr_o |
| rx_addr_o | output | CNT_W | Receive buffer byte address |
| rx_wr_o | output | 1 | Receive write strobe |
| rx_data_o | output | 8 | Receive byte to write |
| rx_amount_o | output | CNT_W | Bytes written in the last granted transaction |
| tx_amount_o | output | CNT_W | Buffer bytes sent in the last granted transaction |
| overflow_o | output | 1 | Sticky receive overflow flag |
| overread_o | output | 1 | Sticky transmit over-read flag |
| clr_overflow_i | input | 1 | Write-one-to-clear for overflow_o |
| clr_overread_i | input | 1 | Write-one-to-clear for overread_o |
| end_rx_o | output | 1 | Pulse when the receive buffer reaches its limit |
| end_o | output | 1 | Pulse at the end of a granted transaction |

## Verification
The bench builds the engine with its defaults: 13-bit counts and two synchronizer stages. It drives small limits from 0 to 8, so every limit, the overflow and over-read paths and the zero-limit case are reached within a few bytes. SCK runs at one sixteenth of the system clock. That keeps the two-stage synchronizer latency well inside half an SCK period in every mode and exposes the first-bit timing of both clock phases.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spx_pin_front.sv
module spx_pin_front #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sel_o,
  output logic mosi_o,
  output logic start_o,
  output logic stop_o,
  output logic sample_o,
  output logic shift_o
);
  // bit 2 = sck, bit 1 = csn, bit 0 = mosi
  localparam logic [2:0] IDLE = 3'b010;

  logic [STAGES-1:0][2:0] chain_q;
  logic sck_d_q, csn_d_q;
  logic sck_s, csn_s, rise, fall, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{IDLE}};
      sck_d_q <= 1'b0;
      csn_d_q <= 1'b1;
    end else begin
      chain_q[0] <= {sck_i, csn_i, mosi_i};
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      sck_d_q <= chain_q[STAGES-1][2];
      csn_d_q <= chain_q[STAGES-1][1];
    end
  end

  assign sck_s  = chain_q[STAGES-1][2];
  assign csn_s  = chain_q[STAGES-1][1];
  assign mosi_o = chain_q[STAGES-1][0];

  assign rise  = sck_s & ~sck_d_q;
  assign fall  = ~sck_s & sck_d_q;
  assign lead  = cpol_i ? fall : rise;
  assign trail = cpol_i ? rise : fall;

  assign sel_o    = ~csn_s;
  assign start_o  = csn_d_q & ~csn_s;
  assign stop_o   = ~csn_d_q & csn_s;
  assign sample_o = sel_o & (cpha_i ? trail : lead);
  assign shift_o  = sel_o & (cpha_i ? lead : trail);
endmodule

// File: rtl/spx_shift.sv
module spx_shift
  import spx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic                 mosi_i,
  input  logic                 lsb_first_i,
  input  byte_t                tx_byte_i,
  input  logic [BIT_IDX_W-1:0] out_idx_i,
  output byte_t                rx_next_o,
  output logic                 bit_o
);
  byte_t rx_sr_q;
  logic [BIT_IDX_W-1:0] sel_idx;

  assign rx_next_o = lsb_first_i ? {mosi_i, rx_sr_q[BYTE_W-1:1]}
                                 : {rx_sr_q[BYTE_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_sr_q <= '0;
    else if (sample_i) rx_sr_q <= rx_next_o;
  end

  assign sel_idx = lsb_first_i ? out_idx_i : BIT_IDX_W'(BYTE_W - 1) - out_idx_i;
  assign bit_o   = tx_byte_i[sel_idx];
endmodule

// File: rtl/spi_slave_xfer.sv
module spi_slave_xfer
  import spx_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lsb_first_i,
  input  logic [CNT_W-1:0] max_rx_i,
  input  logic [CNT_W-1:0] max_tx_i,
  input  logic [7:0]       def_char_i,
  input  logic [7:0]       orc_char_i,
  input  logic             grant_i,
  output logic [CNT_W-1:0] tx_addr_o,
  output logic             tx_rd_o,
  input  logic [7:0]       tx_data_i,
  output logic [CNT_W-1:0] rx_addr_o,
  output logic             rx_wr_o,
  output logic [7:0]       rx_data_o,
  output logic [CNT_W-1:0] rx_amount_o,
  output logic [CNT_W-1:0] tx_amount_o,
  output logic             overflow_o,
  output logic             overread_o,
  input  logic             clr_overflow_i,
  input  logic             clr_overread_i,
  output logic             end_rx_o,
  output logic             end_o
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

  logic sel, mosi_s, start, stop, sample, shift;

  spx_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .sck_i, .csn_i, .mosi_i, .cpol_i, .cpha_i,
    .sel_o(sel), .mosi_o(mosi_s), .start_o(start), .stop_o(stop),
    .sample_o(sample), .shift_o(shift)
  );

  logic                 granted_q, cur_fill_q, pend_q;
  logic [BIT_IDX_W-1:0] in_bit_q, out_idx_q;
  byte_t                tx_byte_q, rx_next;
  logic [CNT_W-1:0]     ld_cnt_q, done_cnt_q, rx_cnt_q;
  logic                 miso_bit;

  spx_shift u_shift (
    .clk_i, .rst_ni, .sample_i(sample), .mosi_i(mosi_s), .lsb_first_i,
    .tx_byte_i(tx_byte_q), .out_idx_i(out_idx_q),
    .rx_next_o(rx_next), .bit_o(miso_bit)
  );

  // transmit byte fetch: first byte at select, later ones on the shift edge after a byte ends
  logic             eff_grant, from_buf, fetch;
  logic [CNT_W-1:0] ld_idx;
  byte_t            fetched;

  always_comb begin
    eff_grant = start ? grant_i : granted_q;
    ld_idx    = start ? '0 : ld_cnt_q;
    from_buf  = eff_grant && (ld_idx < max_tx_i);
    fetch     = start || (shift && pend_q);
    if (!eff_grant)    fetched = def_char_i;
    else if (from_buf) fetched = tx_data_i;
    else               fetched = orc_char_i;
  end

  assign tx_addr_o = ld_idx;
  assign tx_rd_o   = fetch && from_buf;
  assign miso_oe_o = sel;
  assign miso_o    = sel & miso_bit;

  logic byte_done, rx_room, ovf_set, ovr_set;
  assign byte_done = sample && (in_bit_q == LAST_BIT);
  assign rx_room   = rx_cnt_q < max_rx_i;
  assign ovf_set   = byte_done && granted_q && !rx_room;
  assign ovr_set   = sample && granted_q && cur_fill_q && (in_bit_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      granted_q   <= 1'b0;
      cur_fill_q  <= 1'b0;
      pend_q      <= 1'b0;
      in_bit_q    <= '0;
      out_idx_q   <= '0;
      tx_byte_q   <= '0;
      ld_cnt_q    <= '0;
      done_cnt_q  <= '0;
      rx_cnt_q    <= '0;
      rx_wr_o     <= 1'b0;
      rx_addr_o   <= '0;
      rx_data_o   <= '0;
      end_rx_o    <= 1'b0;
      end_o       <= 1'b0;
      rx_amount_o <= '0;
      tx_amount_o <= '0;
    end else begin
      rx_wr_o  <= 1'b0;
      end_rx_o <= 1'b0;
      end_o    <= 1'b0;
      if (start) begin
        granted_q  <= grant_i;
        in_bit_q   <= '0;
        out_idx_q  <= '0;
        rx_cnt_q   <= '0;
        done_cnt_q <= '0;
      end
      if (fetch) begin
        tx_byte_q  <= fetched;
        cur_fill_q <= eff_grant && !from_buf;
        ld_cnt_q   <= ld_idx + CNT_W'(from_buf);
        pend_q     <= 1'b0;
      end
      if (shift) out_idx_q <= in_bit_q;
      if (sample) begin
        in_bit_q <= in_bit_q + 1'b1;
        if (byte_done) begin
          pend_q <= 1'b1;
          if (granted_q && !cur_fill_q) done_cnt_q <= done_cnt_q + 1'b1;
          if (granted_q && rx_room) begin
            rx_wr_o   <= 1'b1;
            rx_addr_o <= rx_cnt_q;
            rx_data_o <= rx_next;
            rx_cnt_q  <= rx_cnt_q + 1'b1;
            end_rx_o  <= (rx_cnt_q + 1'b1) == max_rx_i;
          end
        end
      end
      if (stop) begin
        if (granted_q) begin
          rx_amount_o <= rx_cnt_q;
          tx_amount_o <= done_cnt_q;
          end_o       <= 1'b1;
        end
        granted_q <= 1'b0;
      end
    end
  end

  // sticky flags, set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overflow_o <= 1'b0;
      overread_o <= 1'b0;
    end else begin
      if (ovf_set)             overflow_o <= 1'b1;
      else if (clr_overflow_i) overflow_o <= 1'b0;
      if (ovr_set)             overread_o <= 1'b1;
      else if (clr_overread_i) overread_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spx_checks.sv
module spx_checks #(
  parameter int CNT_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csn_i,
  input logic             miso_oe_o,
  input logic             rx_wr_o,
  input logic [CNT_W-1:0] rx_addr_o,
  input logic [CNT_W-1:0] max_rx_i,
  input logic             tx_rd_o,
  input logic [CNT_W-1:0] tx_addr_o,
  input logic [CNT_W-1:0] max_tx_i,
  input logic             end_rx_o,
  input logic             overflow_o,
  input logic             clr_overflow_i,
  input logic             overread_o,
  input logic             clr_overread_i,
  input logic             end_o
);
  localparam int HI_LIM = SYNC_STAGES + 1;
  int unsigned csn_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     csn_hi_cnt <= 0;
    else if (!csn_i)                 csn_hi_cnt <= 0;
    else if (csn_hi_cnt < HI_LIM)    csn_hi_cnt <= csn_hi_cnt + 1;
  end

  // R3
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_hi_cnt >= HI_LIM) |-> !miso_oe_o);
  // R5
  rx_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wr_o |-> (rx_addr_o < max_rx_i));
  // R6
  tx_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rd_o |-> (tx_addr_o < max_tx_i));
  // R8
  end_rx_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_rx_o |-> rx_wr_o);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr_overflow_i) |=> overflow_o);
  // R6
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overread_o && !clr_overread_i) |=> overread_o);
  // R9
  end_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
endmodule

bind spi_slave_xfer spx_checks #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_i(csn_i), .miso_oe_o(miso_oe_o),
  .rx_wr_o(rx_wr_o), .rx_addr_o(rx_addr_o), .max_rx_i(max_rx_i),
  .tx_rd_o(tx_rd_o), .tx_addr_o(tx_addr_o), .max_tx_i(max_tx_i),
  .end_rx_o(end_rx_o), .overflow_o(overflow_o), .clr_overflow_i(clr_overflow_i),
  .overread_o(overread_o), .clr_overread_i(clr_overread_i), .end_o(end_o)
);

// File: tb/tb_spi_slave_xfer.sv
module tb_spi_slave_xfer;
  localparam int CNT_W = 13;
  localparam int H     = 8;
  localparam logic [7:0] DEF = 8'h5A;
  localparam logic [7:0] ORC = 8'hC3;

  // {cpol, cpha, lsb, grant, max_rx[3:0], max_tx[3:0], nbytes[3:0]}
  localparam logic [15:0] VEC [8] = '{
    16'h1443, 16'h7254, 16'h9524, 16'hF333,
    16'h2442, 16'hD002, 16'h5615, 16'hA113
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, grant = 1'b0;
  logic [CNT_W-1:0] max_rx = '0, max_tx = '0;
  logic clr_ovf = 1'b0, clr_ovr = 1'b0;
  logic miso, miso_oe, tx_rd, rx_wr, ovf, ovr, end_rx, end_p;
  logic [CNT_W-1:0] tx_addr, rx_addr, rx_amt, tx_amt;
  logic [7:0] tx_data, rx_data;
  int seed = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] tx_val(int a, int s);
    return 8'(8'h61 + a * 29 + s * 7);
  endfunction
  function automatic logic [7:0] mosi_val(int k, int s);
    return 8'(8'h3C ^ (k * 37) ^ (s * 11));
  endfunction

  assign tx_data = tx_val(int'(tx_addr), seed);

  spi_slave_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb), .max_rx_i(max_rx), .max_tx_i(max_tx),
    .def_char_i(DEF), .orc_char_i(ORC), .grant_i(grant),
    .tx_addr_o(tx_addr), .tx_rd_o(tx_rd), .tx_data_i(tx_data),
    .rx_addr_o(rx_addr), .rx_wr_o(rx_wr), .rx_data_o(rx_data),
    .rx_amount_o(rx_amt), .tx_amount_o(tx_amt), .overflow_o(ovf),
    .overread_o(ovr), .clr_overflow_i(clr_ovf), .clr_overread_i(clr_ovr),
    .end_rx_o(end_rx), .end_o(end_p)
  );

  logic [7:0] rxmem [16];
  int wr_cnt = 0, end_cnt = 0, endrx_cnt = 0;
  always @(posedge clk) begin
    if (rx_wr) begin
      rxmem[rx_addr[3:0]] <= rx_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (end_p)  end_cnt   <= end_cnt + 1;
    if (end_rx) endrx_cnt <= endrx_cnt + 1;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] cap [16];
  int oe_low = 0;

  // master: nb whole bytes then xbits bits of a partial byte
  task automatic spi_xfer(input int nb, input int xbits);
    int total;
    total = nb + ((xbits > 0) ? 1 : 0);
    sck = cpol;
    tick(2);
    csn = 1'b0;
    tick(H);
    for (int k = 0; k < total; k++) begin
      logic [7:0] mb;
      int nbits;
      mb = mosi_val(k, seed);
      nbits = (k < nb) ? 8 : xbits;
      cap[k] = '0;
      for (int j = 0; j < nbits; j++) begin
        int bp;
        bp = lsb ? j : 7 - j;
        if (!cpha) begin
          mosi = mb[bp];
          tick(H);
          cap[k][bp] = miso;
          if (!miso_oe) oe_low++;
          sck = ~cpol;
          tick(H);
          sck = cpol;
        end else begin
          sck = ~cpol;
          mosi = mb[bp];
          tick(H);
          cap[k][bp] = miso;
          if (!miso_oe) oe_low++;
          sck = cpol;
          tick(H);
        end
      end
    end
    tick(H);
    csn = 1'b1;
    tick(3 * H);
  endtask

  int exp_rx_amt = 0, exp_tx_amt = 0;

  initial begin
    tick(4);
    // R12 reset state
    chk(miso_oe == 1'b0, "R12", "miso_oe after reset", miso_oe, 0);
    chk(ovf == 1'b0 && ovr == 1'b0, "R12", "flags after reset", {ovf, ovr}, 0);
    chk(rx_amt == '0 && tx_amt == '0, "R12", "amounts after reset", rx_amt + tx_amt, 0);
    chk(end_p == 1'b0 && end_rx == 1'b0 && rx_wr == 1'b0, "R12", "pulses after reset",
        {end_p, end_rx, rx_wr}, 0);
    rst_n = 1'b1;
    tick(4);
    chk(miso_oe == 1'b0 && miso == 1'b0, "R3", "idle MISO", {miso_oe, miso}, 0);

    // vector table: R1 R2 modes and orders, R4..R9 limits and pulses
    for (int v = 0; v < 8; v++) begin
      int nb, mrx, mtx, w0, e0, r0, bad, nrx, ntx;
      bit g;
      seed = v + 1;
      {cpol, cpha, lsb, g} = VEC[v][15:12];
      mrx = int'(VEC[v][11:8]);
      mtx = int'(VEC[v][7:4]);
      nb  = int'(VEC[v][3:0]);
      grant = g;
      max_rx = CNT_W'(mrx);
      max_tx = CNT_W'(mtx);
      clr_ovf = 1'b1; clr_ovr = 1'b1;
      tick(1);
      clr_ovf = 1'b0; clr_ovr = 1'b0;
      tick(1);
      chk(ovf == 1'b0 && ovr == 1'b0, "R10", "flags after clear", {ovf, ovr}, 0);
      w0 = wr_cnt; e0 = end_cnt; r0 = endrx_cnt; oe_low = 0;
      spi_xfer(nb, 0);
      bad = 0;
      for (int k = 0; k < nb; k++) begin
        logic [7:0] e;
        e = !g ? DEF : (k < mtx) ? tx_val(k, seed) : ORC;
        if (cap[k] !== e) bad++;
      end
      chk(bad == 0, g ? "R1" : "R4", $sformatf("vec%0d MISO bytes wrong (R2 order)", v), bad, 0);
      chk(oe_low == 0, "R3", "oe low while selected", oe_low, 0);
      nrx = g ? ((nb < mrx) ? nb : mrx) : 0;
      ntx = (nb < mtx) ? nb : mtx;
      chk(wr_cnt - w0 == nrx, "R5", $sformatf("vec%0d write count", v), wr_cnt - w0, nrx);
      bad = 0;
      for (int k = 0; k < nrx; k++) if (rxmem[k] !== mosi_val(k, seed)) bad++;
      chk(bad == 0, "R1", $sformatf("vec%0d rx bytes wrong (R2 order)", v), bad, 0);
      if (g) begin
        exp_rx_amt = nrx;
        exp_tx_amt = ntx;
      end
      chk(int'(rx_amt) == exp_rx_amt, g ? "R7" : "R4", "rx amount", int'(rx_amt), exp_rx_amt);
      chk(int'(tx_amt) == exp_tx_amt, g ? "R7" : "R4", "tx amount", int'(tx_amt), exp_tx_amt);
      chk(ovf == (g && nb > mrx), "R5", $sformatf("vec%0d overflow", v), ovf, g && nb > mrx);
      chk(ovr == (g && nb > mtx), "R6", $sformatf("vec%0d overread", v), ovr, g && nb > mtx);
      chk(end_cnt - e0 == (g ? 1 : 0), "R9", "end pulses", end_cnt - e0, g ? 1 : 0);
      chk(endrx_cnt - r0 == ((g && mrx > 0 && nb >= mrx) ? 1 : 0), "R8", "end_rx pulses",
          endrx_cnt - r0, (g && mrx > 0 && nb >= mrx) ? 1 : 0);
      chk(miso_oe == 1'b0, "R3", "oe after deselect", miso_oe, 0);
    end

    // R10: clear one flag only
    cpol = 0; cpha = 0; lsb = 0; grant = 1; seed = 20;
    max_rx = 13'd1; max_tx = 13'd1;
    spi_xfer(2, 0);
    chk(ovf && ovr, "R10", "both flags set before clear", {ovf, ovr}, 3);
    clr_ovf = 1'b1; tick(1); clr_ovf = 1'b0; tick(1);
    chk(!ovf && ovr, "R10", "only overflow cleared", {ovf, ovr}, 1);
    clr_ovr = 1'b1; tick(1); clr_ovr = 1'b0; tick(1);
    chk(!ovr, "R10", "overread cleared", ovr, 0);

    // R11: partial byte abandoned
    begin
      int w0;
      seed = 21; max_rx = 13'd8; max_tx = 13'd8;
      w0 = wr_cnt;
      spi_xfer(2, 3);
      chk(wr_cnt - w0 == 2, "R11", "writes with partial byte", wr_cnt - w0, 2);
      chk(rx_amt == 13'd2, "R11", "rx amount with partial byte", int'(rx_amt), 2);
      chk(tx_amt == 13'd2, "R11", "tx amount with partial byte", int'(tx_amt), 2);
      chk(!ovf && !ovr, "R11", "no flags with partial byte", {ovf, ovr}, 0);
    end

    // R4: grant rising mid-transaction has no effect
    begin
      int w0, e0, bad;
      seed = 22; grant = 1'b0; cpha = 1'b1; lsb = 1'b1;
      w0 = wr_cnt; e0 = end_cnt;
      fork
        spi_xfer(3, 0);
        begin tick(5 * H); grant = 1'b1; end
      join
      bad = 0;
      for (int k = 0; k < 3; k++) if (cap[k] !== DEF) bad++;
      chk(bad == 0, "R4", "late grant MISO bytes", bad, 0);
      chk(wr_cnt == w0, "R4", "late grant writes", wr_cnt - w0, 0);
      chk(end_cnt == e0, "R4", "late grant end pulse", end_cnt - e0, 0);
      chk(rx_amt == 13'd2, "R4", "late grant rx amount kept", int'(rx_amt), 2);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule